// File: doc/BRIEF.md
# Address-Decoded Math Operation Dispatcher

This block is the memory-mapped front end of a math accelerator. A single bus write of an operand starts an operation: the upper part of the write offset picks the function, the entry within that function's bank picks the destination result register, and the write data is the first input. The block forwards a tagged request to an external fixed-latency compute pipeline. It steers the returning data into an eight-entry result register file, and it serves bus reads of that file.

Two-input operations take their second input from a separate operand2 register, which software loads before it makes the triggering write. The quadrant/ratio operation returns two words and fills a pair of adjacent result registers. A pending bit for each result register holds off a read until the data for that register has arrived. Pipeline error reports are latched into two sticky interrupt flags, and software clears them through a status register.

Top module: `mop_dispatch`

## Requirements
- R1: A write at an aligned offset whose bits [9:6] select bank 1, 2, 3, 5, 6 or 7 issues one request on the cycle after the write. The bank maps to req_op 0 (sine), 1 (cosine), 2 (arctangent), 3 (inverse exponent), 4 (logarithm) and 5 (quadrant/ratio). Offset bits [5:3] become req_tag, and the write data becomes req_a.
- R2: A write to offset 0x240 loads the operand2 register. Every later request carries that value on req_b until the register is written again.
- R3: The quadrant bank at 0x1C0 has entries 0 to 6. Its response, flagged by rsp_two, stores rsp_d0 into R[tag] and rsp_d1 into R[tag+1].
- R4: A response stores rsp_d0 into R[rsp_tag] and clears the pending bits of every register it writes.
- R5: An issue sets the pending bit of each destination register. A read of a pending result register gets no rd_ack until that register has been written back, and it then returns the new value.
- R6: A read of offset 0x280+8n returns Rn. For a register that is not pending, rd_ack rises one cycle after rd_req is sampled, with the data on rd_data. Each request gets exactly one ack, and result registers reset to zero.
- R7: A write to an unmapped offset issues no request and changes no state. Unmapped offsets include those with bits [2:0] nonzero, offset 0x000 and quadrant entry 7 (0x1F8). A read of an unmapped offset, including 0x240, returns zero.
- R8: rsp_unf and rsp_ovf set irq_unf and irq_ovf, and both flags stay set until cleared. A read of 0x300 returns irq_unf in bit 0 and irq_ovf in bit 1. Writing 1 to those bits at 0x300 clears the flags, except that an error reported in the same cycle keeps its flag set.
- R9: When a new issue and a write-back target the same register in the same cycle, the register stays pending, and a later read returns the result of the new issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | AW | Bus write byte offset |
| wr_data | input | DW | Bus write data |
| rd_req | input | 1 | Bus read request, held until rd_ack |
| rd_addr | input | AW | Bus read byte offset |
| rd_ack | output | 1 | Read data valid, one pulse per request |
| rd_data | output | DW | Read data |
| req_valid | output | 1 | Request to compute pipeline |
| req_op | output | 3 | Operation code |
| req_tag | output | TW | Destination register index |
| req_a | output | DW | First input |
| req_b | output | DW | Second input |
| rsp_valid | input | 1 | Pipeline response strobe |
| rsp_tag | input | TW | Response destination index |
| rsp_two | input | 1 | Response carries a second word |
| rsp_d0 | input | DW | First result word |
| rsp_d1 | input | DW | Second result word |
| rsp_unf | input | 1 | Underflow report |
| rsp_ovf | input | 1 | Overflow report |
| irq_unf | output | 1 | Sticky underflow interrupt |
| irq_ovf | output | 1 | Sticky overflow interrupt |

## Verification
Two collisions can fall in a single cycle. The first is a new operand write and the write-back of an older operation to the same result register. The bench times the second write to land on the exact edge where the pipeline model returns the first result, then reads that register. The read must stall and then return the second result. The second collision is a status clear and a fresh error report. The bench aligns the clear write with the response edge of an erroring operation and judges the flag, which must stay set.

// File: rtl/mop_pkg.sv
package mop_pkg;
  typedef enum logic [2:0] {
    OP_SIN  = 3'd0,
    OP_COS  = 3'd1,
    OP_ATAN = 3'd2,
    OP_IEXP = 3'd3,
    OP_LOG  = 3'd4,
    OP_QUAD = 3'd5
  } op_e;

  // bank numbers come from offset bits [9:6]
  localparam logic [3:0] BANK_SIN  = 4'd1;
  localparam logic [3:0] BANK_COS  = 4'd2;
  localparam logic [3:0] BANK_ATAN = 4'd3;
  localparam logic [3:0] BANK_IEXP = 4'd5;
  localparam logic [3:0] BANK_LOG  = 4'd6;
  localparam logic [3:0] BANK_QUAD = 4'd7;
  localparam logic [3:0] BANK_OP2  = 4'd9;
  localparam logic [3:0] BANK_RES  = 4'd10;
  localparam logic [3:0] BANK_STAT = 4'd12;

  typedef struct packed {
    logic       issue;
    logic       op2_wr;
    logic       stat_wr;
    op_e        op;
    logic [2:0] tag;
  } wdec_t;

  function automatic wdec_t dec_write(input logic [9:0] off);
    wdec_t d;
    logic  al;
    d     = '{issue: 1'b0, op2_wr: 1'b0, stat_wr: 1'b0, op: OP_SIN, tag: off[5:3]};
    al    = (off[2:0] == 3'b000);
    if (al) begin
      case (off[9:6])
        BANK_SIN:  begin d.issue = 1'b1; d.op = OP_SIN;  end
        BANK_COS:  begin d.issue = 1'b1; d.op = OP_COS;  end
        BANK_ATAN: begin d.issue = 1'b1; d.op = OP_ATAN; end
        BANK_IEXP: begin d.issue = 1'b1; d.op = OP_IEXP; end
        BANK_LOG:  begin d.issue = 1'b1; d.op = OP_LOG;  end
        BANK_QUAD: begin d.issue = (off[5:3] != 3'd7); d.op = OP_QUAD; end
        BANK_OP2:  d.op2_wr  = (off[5:3] == 3'd0);
        BANK_STAT: d.stat_wr = (off[5:3] == 3'd0);
        default:   d.issue   = 1'b0;
      endcase
    end
    return d;
  endfunction

  // mask of result registers touched by one event (one or a pair)
  function automatic logic [7:0] dest_mask(input logic [2:0] tag, input logic pair);
    logic [7:0] m;
    m = 8'b1 << tag;
    if (pair && tag != 3'd7) m = m | (8'b1 << (tag + 3'd1));
    return m;
  endfunction
endpackage

// File: rtl/mop_decode.sv
module mop_decode
  import mop_pkg::*;
#(
  parameter int AW = 10,
  parameter int TW = 3
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] rd_addr,
  output logic          dec_issue,
  output logic          dec_op2,
  output logic          dec_stat,
  output op_e           dec_op,
  output logic [TW-1:0] dec_tag,
  output logic          rd_is_res,
  output logic          rd_is_stat,
  output logic [TW-1:0] rd_idx
);
  wdec_t w;
  logic  rd_al;

  always_comb begin
    w          = dec_write(wr_addr[9:0]);
    dec_issue  = wr_en & w.issue;
    dec_op2    = wr_en & w.op2_wr;
    dec_stat   = wr_en & w.stat_wr;
    dec_op     = w.op;
    dec_tag    = w.tag;
    rd_al      = (rd_addr[2:0] == 3'b000);
    rd_idx     = rd_addr[5:3];
    rd_is_res  = rd_al && (rd_addr[9:6] == BANK_RES);
    rd_is_stat = rd_al && (rd_addr[9:6] == BANK_STAT) && (rd_addr[5:3] == 3'd0);
  end
endmodule

// File: rtl/mop_track.sv
module mop_track #(
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] set_mask,
  input  logic [NREG-1:0] clr_mask,
  output logic [NREG-1:0] pend
);
  // a new issue wins over a same-cycle write-back
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_mask) | set_mask;
  end

  assert_issue_sets_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((pend & $past(set_mask)) == $past(set_mask)));

  assert_wb_clears_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_mask & ~set_mask) != '0) |=> ((pend & $past(clr_mask & ~set_mask)) == '0));

  assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_mask & clr_mask) != '0) |=> ((pend & $past(set_mask & clr_mask)) == $past(set_mask & clr_mask)));
endmodule

// File: rtl/mop_rfile.sv
module mop_rfile #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  localparam int TW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wb_vld,
  input  logic [TW-1:0] wb_tag,
  input  logic          wb_two,
  input  logic [DW-1:0] wb_d0,
  input  logic [DW-1:0] wb_d1,
  output logic [DW-1:0] rf [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_ent
    localparam logic [TW-1:0] ME   = TW'(g);
    localparam logic [TW-1:0] PREV = TW'((g + NREG - 1) % NREG);
    logic hit_lo, hit_hi;
    assign hit_lo = wb_vld && (wb_tag == ME);
    assign hit_hi = wb_vld && wb_two && (g > 0) && (wb_tag == PREV);
    always_ff @(posedge clk) begin
      if (!rst_n)      rf[g] <= '0;
      else if (hit_lo) rf[g] <= wb_d0;
      else if (hit_hi) rf[g] <= wb_d1;
    end
  end

  assert_wb_first_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_vld |=> (rf[$past(wb_tag)] == $past(wb_d0)));

  assert_wb_pair_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_vld && wb_two && (wb_tag != TW'(NREG - 1))) |=> (rf[$past(wb_tag) + TW'(1)] == $past(wb_d1)));
endmodule

// File: rtl/mop_dispatch.sv
module mop_dispatch
  import mop_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 10,
  parameter int NREG = 8,
  localparam int TW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_ack,
  output logic [DW-1:0] rd_data,
  output logic          req_valid,
  output logic [2:0]    req_op,
  output logic [TW-1:0] req_tag,
  output logic [DW-1:0] req_a,
  output logic [DW-1:0] req_b,
  input  logic          rsp_valid,
  input  logic [TW-1:0] rsp_tag,
  input  logic          rsp_two,
  input  logic [DW-1:0] rsp_d0,
  input  logic [DW-1:0] rsp_d1,
  input  logic          rsp_unf,
  input  logic          rsp_ovf,
  output logic          irq_unf,
  output logic          irq_ovf
);
  logic          dec_issue, dec_op2, dec_stat;
  op_e           dec_op;
  logic [TW-1:0] dec_tag;
  logic          rd_is_res, rd_is_stat;
  logic [TW-1:0] rd_idx;
  logic [DW-1:0] op2_q;
  logic [NREG-1:0] set_mask, clr_mask, pend;
  logic [DW-1:0] rf [NREG];
  logic          pend_hit, clr_unf, clr_ovf;

  mop_decode #(.AW(AW), .TW(TW)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .dec_issue(dec_issue), .dec_op2(dec_op2), .dec_stat(dec_stat),
    .dec_op(dec_op), .dec_tag(dec_tag),
    .rd_is_res(rd_is_res), .rd_is_stat(rd_is_stat), .rd_idx(rd_idx)
  );

  always_comb begin
    set_mask = dec_issue ? NREG'(dest_mask(3'(dec_tag), dec_op == OP_QUAD)) : '0;
    clr_mask = rsp_valid ? NREG'(dest_mask(3'(rsp_tag), rsp_two)) : '0;
    pend_hit = rd_is_res && pend[rd_idx];
    clr_unf  = dec_stat && wr_data[0];
    clr_ovf  = dec_stat && wr_data[1];
  end

  mop_track #(.NREG(NREG)) u_trk (
    .clk(clk), .rst_n(rst_n), .set_mask(set_mask), .clr_mask(clr_mask), .pend(pend)
  );

  mop_rfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk(clk), .rst_n(rst_n), .wb_vld(rsp_valid), .wb_tag(rsp_tag), .wb_two(rsp_two),
    .wb_d0(rsp_d0), .wb_d1(rsp_d1), .rf(rf)
  );

  // operand2 and request stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op2_q     <= '0;
      req_valid <= 1'b0;
      req_op    <= 3'd0;
      req_tag   <= '0;
      req_a     <= '0;
      req_b     <= '0;
    end else begin
      if (dec_op2) op2_q <= wr_data;
      req_valid <= dec_issue;
      if (dec_issue) begin
        req_op  <= 3'(dec_op);
        req_tag <= dec_tag;
        req_a   <= wr_data;
        req_b   <= op2_q;
      end
    end
  end

  // sticky error flags: a fresh report beats a clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_unf <= 1'b0;
      irq_ovf <= 1'b0;
    end else begin
      irq_unf <= (irq_unf && !clr_unf) || (rsp_valid && rsp_unf);
      irq_ovf <= (irq_ovf && !clr_ovf) || (rsp_valid && rsp_ovf);
    end
  end

  // read port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack <= rd_req && !rd_ack && !pend_hit;
      if (rd_is_res)       rd_data <= rf[rd_idx];
      else if (rd_is_stat) rd_data <= DW'({irq_ovf, irq_unf});
      else                 rd_data <= '0;
    end
  end

  assert_req_after_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(wr_en));

  assert_ack_after_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> ($past(rd_req) && !$past(rd_ack)));

  assert_no_ack_while_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> !$past(pend_hit));

  assert_unf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_unf && !clr_unf) |=> irq_unf);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ovf && !clr_ovf) |=> irq_ovf);
endmodule

// File: tb/mop_dispatch_tb.sv
module mop_dispatch_tb;
  localparam int DW = 32, AW = 10, NREG = 8, TW = 3, LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          wr_en = 1'b0, rd_req = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_ack, req_valid, irq_unf, irq_ovf;
  logic [DW-1:0] rd_data, req_a, req_b;
  logic [2:0]    req_op;
  logic [TW-1:0] req_tag;
  logic          rsp_valid, rsp_two, rsp_unf, rsp_ovf;
  logic [TW-1:0] rsp_tag;
  logic [DW-1:0] rsp_d0, rsp_d1;

  mop_dispatch #(.DW(DW), .AW(AW), .NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .req_valid(req_valid), .req_op(req_op), .req_tag(req_tag), .req_a(req_a), .req_b(req_b),
    .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_two(rsp_two), .rsp_d0(rsp_d0),
    .rsp_d1(rsp_d1), .rsp_unf(rsp_unf), .rsp_ovf(rsp_ovf), .irq_unf(irq_unf), .irq_ovf(irq_ovf)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench-side kernels of the compute pipeline
  function automatic logic [DW-1:0] k_first(input logic [2:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    return (a ^ (32'h1111_1111 * ({29'd0, op} + 32'd1))) + b;
  endfunction
  function automatic logic [DW-1:0] k_second(input logic [DW-1:0] a, input logic [DW-1:0] b);
    return a - b;
  endfunction

  // pipeline model, LAT stages shifted on the falling edge
  logic          p_v [LAT];
  logic [2:0]    p_op [LAT];
  logic [TW-1:0] p_tag [LAT];
  logic [DW-1:0] p_a [LAT], p_b [LAT];
  initial for (int i = 0; i < LAT; i++) begin p_v[i] = 0; p_op[i] = 0; p_tag[i] = 0; p_a[i] = 0; p_b[i] = 0; end
  always @(negedge clk) begin
    for (int i = LAT - 1; i > 0; i--) begin
      p_v[i] <= p_v[i-1]; p_op[i] <= p_op[i-1]; p_tag[i] <= p_tag[i-1]; p_a[i] <= p_a[i-1]; p_b[i] <= p_b[i-1];
    end
    p_v[0] <= req_valid; p_op[0] <= req_op; p_tag[0] <= req_tag; p_a[0] <= req_a; p_b[0] <= req_b;
  end
  assign rsp_valid = p_v[LAT-1];
  assign rsp_tag   = p_tag[LAT-1];
  assign rsp_two   = (p_op[LAT-1] == 3'd5);
  assign rsp_d0    = k_first(p_op[LAT-1], p_a[LAT-1], p_b[LAT-1]);
  assign rsp_d1    = k_second(p_a[LAT-1], p_b[LAT-1]);
  assign rsp_unf   = (p_a[LAT-1][31:28] == 4'hE);
  assign rsp_ovf   = (p_a[LAT-1][31:28] == 4'hF);

  // scoreboards
  typedef struct packed { logic [2:0] op; logic [TW-1:0] tag; logic [DW-1:0] a; logic [DW-1:0] b; } req_t;
  req_t          exp_req [$];
  logic [DW-1:0] exp_rd [$];
  string         exp_rd_tag [$];
  logic [DW-1:0] m_res [NREG];
  logic [DW-1:0] m_op2 = '0;

  always @(negedge clk) begin
    if (req_valid) begin
      if (exp_req.size() == 0) chk(1'b0, "R7 unexpected request", req_a, '0);
      else begin
        req_t e;
        e = exp_req.pop_front();
        chk(req_op == e.op && req_tag == e.tag, "R1 request op/tag", {26'd0, req_op, req_tag}, {26'd0, e.op, e.tag});
        chk(req_a == e.a, "R1 request operand1", req_a, e.a);
        chk(req_b == e.b, "R2 request operand2", req_b, e.b);
      end
    end
    if (rd_ack) begin
      if (exp_rd.size() == 0) chk(1'b0, "R6 unrequested ack", rd_data, '0);
      else begin
        logic [DW-1:0] e;
        string t;
        e = exp_rd.pop_front();
        t = exp_rd_tag.pop_front();
        chk(rd_data == e, t, rd_data, e);
      end
    end
  end

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [2:0] bank_op(input logic [AW-1:0] base);
    case (base)
      10'h040: return 3'd0;
      10'h080: return 3'd1;
      10'h0C0: return 3'd2;
      10'h140: return 3'd3;
      10'h180: return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  task automatic issue(input logic [AW-1:0] base, input int n, input logic [DW-1:0] a);
    logic [2:0] op;
    op = bank_op(base);
    exp_req.push_back('{op: op, tag: TW'(n), a: a, b: m_op2});
    m_res[n] = k_first(op, a, m_op2);
    if (op == 3'd5) m_res[n+1] = k_second(a, m_op2);
    bus_wr(base + AW'(8 * n), a);
  endtask

  task automatic set_op2(input logic [DW-1:0] v);
    m_op2 = v;
    bus_wr(10'h240, v);
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, input logic [DW-1:0] e, input string t, output int waited);
    exp_rd.push_back(e); exp_rd_tag.push_back(t);
    rd_addr = a; rd_req = 1'b1; waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!rd_ack && waited < 200);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_res(input int n, input string t);
    int w;
    bus_rd(10'h280 + AW'(8 * n), m_res[n], t, w);
  endtask

  initial begin
    int w;
    for (int i = 0; i < NREG; i++) m_res[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!irq_unf && !irq_ovf, "R8 reset flags", {30'd0, irq_ovf, irq_unf}, '0);
    chk(!req_valid, "R1 reset request idle", {31'd0, req_valid}, '0);
    bus_rd(10'h280, 32'd0, "R6 reset value of R0", w);
    chk(w == 1, "R6 ack one cycle after request", w, 1);

    set_op2(32'h0000_0100);
    issue(10'h040, 0, 32'h0000_1234);
    bus_rd(10'h280, m_res[0], "R5 stalled read of R0", w);
    chk(w > 1, "R5 read of pending register stalled", w, 2);

    issue(10'h080, 1, 32'h0000_2222);
    issue(10'h0C0, 2, 32'h0000_3333);
    issue(10'h140, 5, 32'h0000_4444);
    issue(10'h180, 7, 32'h0000_5555);
    rd_res(1, "R4 cosine into R1");
    rd_res(2, "R4 arctangent into R2");
    rd_res(5, "R4 inverse exponent into R5");
    rd_res(7, "R4 logarithm into R7");

    set_op2(32'h0000_0055);
    issue(10'h1C0, 3, 32'h0000_0777);
    rd_res(3, "R3 ratio into R3");
    rd_res(4, "R3 quadrant into R4");
    issue(10'h1C0, 6, 32'h0000_9999);
    rd_res(7, "R3 quadrant into R7");
    rd_res(6, "R3 ratio into R6");

    // unmapped writes: quadrant entry 7, misaligned, offset zero, gap
    bus_wr(10'h1F8, 32'hDEAD_0001);
    bus_wr(10'h044, 32'hDEAD_0002);
    bus_wr(10'h000, 32'hDEAD_0003);
    bus_wr(10'h244, 32'hDEAD_0004);
    repeat (LAT + 2) @(negedge clk);
    bus_rd(10'h2B8, m_res[7], "R7 R7 untouched by unmapped write", w);
    chk(w == 1, "R7 R7 not left pending", w, 1);
    bus_rd(10'h240, 32'd0, "R7 operand2 offset reads zero", w);
    bus_rd(10'h3F8, 32'd0, "R7 unmapped read zero", w);
    issue(10'h040, 0, 32'h0000_0ABC);
    rd_res(0, "R2 operand2 kept after ignored writes");

    // same-cycle issue and write-back to R2
    issue(10'h0C0, 2, 32'h0000_1111);
    @(negedge clk);
    @(negedge clk);
    issue(10'h080, 2, 32'h0000_2020);
    bus_rd(10'h290, m_res[2], "R9 new result wins after collision", w);
    chk(w > 1, "R9 register still pending after collision", w, 2);

    // sticky error flags
    issue(10'h040, 4, 32'hE000_0000);
    repeat (LAT) @(negedge clk);
    chk(irq_unf && !irq_ovf, "R8 underflow flag set", {30'd0, irq_ovf, irq_unf}, 32'd1);
    repeat (4) @(negedge clk);
    chk(irq_unf, "R8 underflow flag sticky", {31'd0, irq_unf}, 32'd1);
    bus_rd(10'h300, 32'd1, "R8 status read underflow", w);
    bus_wr(10'h300, 32'd1);
    chk(!irq_unf, "R8 underflow cleared", {31'd0, irq_unf}, '0);
    issue(10'h080, 4, 32'hF000_0000);
    repeat (LAT) @(negedge clk);
    bus_rd(10'h300, 32'd2, "R8 status read overflow", w);
    bus_wr(10'h300, 32'd2);
    chk(!irq_ovf, "R8 overflow cleared", {31'd0, irq_ovf}, '0);
    // clear lands on the edge of a fresh underflow report
    issue(10'h0C0, 1, 32'hE000_0001);
    @(negedge clk);
    @(negedge clk);
    bus_wr(10'h300, 32'd1);
    chk(irq_unf, "R8 fresh error beats clear", {31'd0, irq_unf}, 32'd1);
    bus_wr(10'h300, 32'd3);
    chk(!irq_unf && !irq_ovf, "R8 both flags cleared", {30'd0, irq_ovf, irq_unf}, '0);
    rd_res(1, "R4 R1 after error operation");

    repeat (LAT + 2) @(negedge clk);
    chk(exp_req.size() == 0, "R1 all expected requests seen", exp_req.size(), 0);
    chk(exp_rd.size() == 0, "R6 all reads acknowledged", exp_rd.size(), 0);
    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R5 run hung actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule